// File: doc/BRIEF.md
# Masked scalar data-memory access stage

This block is the memory stage of a small processor pipeline. It serves scalar loads and stores against a private 4 KiB data store, organised as 1024 words of 32 bits. Every load and every store, at any width and with or without sign extension, goes through one read-modify-write path. The requester precomputes three values for each request: a read mask, a write mask and a right-shift amount.

In a single cycle the stage does four things. It reads the addressed word and shifts it arithmetically right. It masks the shifted word to form the load result. It then writes back a merge of the old word and the store data, selected bit by bit by the write mask. The load result and the destination register index are registered into the next pipeline latch.

Requests that are not scalar do not touch memory. An idle request carries the upstream result and destination through unchanged. A vector request also carries the result through, but forces the scalar destination index to 0.

Top module: `scalar_dmem_stage`

## Requirements
- R1: While rst_ni is low, wb_result_o and wb_dest_o are 0.
- R2: Only addr_i[11:2] selects the word. Bits 31..12 are ignored, and so are bits 1..0, because lanes are expressed only through the masks and the shift.
- R3: For a scalar request (req_kind_i = 2'b01), wb_result_o after the next rising edge equals rd_mask_i AND (word arithmetically shifted right by shamt_i). The word's bit 31 fills the vacated positions.
- R4: For a scalar request, the stored word becomes (old AND NOT wr_mask_i) OR (st_data_i AND wr_mask_i). Big-endian byte offset 0 occupies bits 31:24 and offset 3 occupies bits 7:0.
- R5: A scalar request with wr_mask_i = 0 leaves the word unchanged.
- R6: An idle request (req_kind_i = 2'b00) registers pass_result_i and pass_dest_i unchanged and modifies no memory word.
- R7: A vector request (req_kind_i = 2'b10 or 2'b11) registers pass_result_i, sets wb_dest_o to 0, and modifies no memory word.
- R8: For a scalar request, wb_dest_o after the next rising edge equals pass_dest_i.
- R9: A scalar request that both reads and writes a word returns the value the word held before that request's write.
- R10: A request issued in the cycle right after a write to the same word observes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_kind_i | input | 2 | 00 idle, 01 scalar, 10/11 vector |
| addr_i | input | 32 | Byte address of the request |
| rd_mask_i | input | 32 | Mask applied to the shifted word |
| wr_mask_i | input | 32 | Per-bit select of store data into the word |
| st_data_i | input | 32 | Store data, already placed in its lanes |
| shamt_i | input | 5 | Arithmetic right-shift amount |
| pass_result_i | input | 32 | Result arriving from the previous stage |
| pass_dest_i | input | 5 | Destination register index from the previous stage |
| wb_result_o | output | 32 | Registered result for write-back |
| wb_dest_o | output | 5 | Registered destination register index |

## Verification
The hardest case to reach from the ports is a request that reads and writes the same word in one cycle. Memory is visible only through later loads, so the pre-write value it returns has to be told apart from the merged value it leaves behind. The stimulus first fills a word with a known pattern. It then issues a store that also carries a full read mask, and the returned value must be the old word. A follow-up load with a full read mask then exposes the merged word. A second store with a zero write mask, sent to a high-bit alias of the same address, confirms that neither aliasing nor an empty mask disturbs the word.

// File: rtl/dmem_stage_pkg.sv
package dmem_stage_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned SHAMT_W   = 5;
  localparam int unsigned REG_IDX_W = 5;

  typedef enum logic [1:0] {
    REQ_IDLE   = 2'b00,
    REQ_SCALAR = 2'b01,
    REQ_VEC    = 2'b10,
    REQ_VEC_B  = 2'b11
  } req_kind_e;

  typedef struct packed {
    logic [XLEN-1:0]      value;
    logic [REG_IDX_W-1:0] dest;
  } wb_latch_t;
endpackage

// File: rtl/dmem_word_array.sv
module dmem_word_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  // Asynchronous read feeds the merge in the same cycle.
  assign rdata_o = mem_q[idx_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end
endmodule

// File: rtl/dmem_load_align.sv
module dmem_load_align #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  word_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  mask_i,
  output logic [DATA_W-1:0]  result_o
);
  logic signed [DATA_W-1:0] word_s;
  logic [DATA_W-1:0]        shifted;

  always_comb begin
    word_s   = $signed(word_i);
    shifted  = DATA_W'(word_s >>> shamt_i);
    result_o = shifted & mask_i;
  end
endmodule

// File: rtl/dmem_store_merge.sv
module dmem_store_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign word_o[b] = mask_i[b] ? data_i[b] : old_i[b];
  end
endmodule

// File: rtl/scalar_dmem_stage.sv
module scalar_dmem_stage
  import dmem_stage_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned BYTES_PER_WORD = XLEN / 8,
  localparam int unsigned LANE_W = $clog2(BYTES_PER_WORD),
  localparam int unsigned WORDS = (2 ** ADDR_W) / BYTES_PER_WORD,
  localparam int unsigned IDX_W = ADDR_W - LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           req_kind_i,
  input  logic [31:0]          addr_i,
  input  logic [XLEN-1:0]      rd_mask_i,
  input  logic [XLEN-1:0]      wr_mask_i,
  input  logic [XLEN-1:0]      st_data_i,
  input  logic [SHAMT_W-1:0]   shamt_i,
  input  logic [XLEN-1:0]      pass_result_i,
  input  logic [REG_IDX_W-1:0] pass_dest_i,
  output logic [XLEN-1:0]      wb_result_o,
  output logic [REG_IDX_W-1:0] wb_dest_o
);
  req_kind_e         kind;
  logic              is_scalar;
  logic [IDX_W-1:0]  word_idx;
  logic [XLEN-1:0]   mem_rdata;
  logic [XLEN-1:0]   mem_wdata;
  logic              mem_we;
  logic [XLEN-1:0]   load_val;
  wb_latch_t         latch_d, latch_q;

  assign kind      = req_kind_e'(req_kind_i);
  assign is_scalar = (kind == REQ_SCALAR);
  assign word_idx  = addr_i[ADDR_W-1:LANE_W];
  assign mem_we    = is_scalar;

  dmem_word_array #(.DATA_W(XLEN), .WORDS(WORDS)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .idx_i   (word_idx),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  dmem_load_align #(.DATA_W(XLEN), .SHAMT_W(SHAMT_W)) u_align (
    .word_i   (mem_rdata),
    .shamt_i  (shamt_i),
    .mask_i   (rd_mask_i),
    .result_o (load_val)
  );

  dmem_store_merge #(.DATA_W(XLEN)) u_merge (
    .old_i  (mem_rdata),
    .data_i (st_data_i),
    .mask_i (wr_mask_i),
    .word_o (mem_wdata)
  );

  always_comb begin
    latch_d.value = pass_result_i;
    latch_d.dest  = pass_dest_i;
    unique case (kind)
      REQ_IDLE:   ;
      REQ_SCALAR: latch_d.value = load_val;
      default:    latch_d.dest  = '0;  // vector data never reaches scalar regs
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= latch_d;
  end

  assign wb_result_o = latch_q.value;
  assign wb_dest_o   = latch_q.dest;
endmodule

// File: rtl/scalar_dmem_stage_chk.sv
module scalar_dmem_stage_chk
  import dmem_stage_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           req_kind_i,
  input logic [XLEN-1:0]      rd_mask_i,
  input logic [XLEN-1:0]      wr_mask_i,
  input logic [SHAMT_W-1:0]   shamt_i,
  input logic [XLEN-1:0]      pass_result_i,
  input logic [REG_IDX_W-1:0] pass_dest_i,
  input logic [XLEN-1:0]      wb_result_o,
  input logic [REG_IDX_W-1:0] wb_dest_o,
  input logic                 mem_we,
  input logic [XLEN-1:0]      mem_rdata,
  input logic [XLEN-1:0]      mem_wdata
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (wb_result_o == '0 && wb_dest_o == '0);
    end
  end

  p_idle_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i == 2'b00) |=> (wb_result_o == $past(pass_result_i) && wb_dest_o == $past(pass_dest_i)));

  p_vec_dest_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i[1]) |=> (wb_dest_o == '0 && wb_result_o == $past(pass_result_i)));

  p_nonscalar_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i != 2'b01) |-> !mem_we);

  p_scalar_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i == 2'b01) |=> (wb_dest_o == $past(pass_dest_i)));

  p_zero_mask_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && wr_mask_i == '0) |-> (mem_wdata == mem_rdata));

  p_load_old_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i == 2'b01 && shamt_i == '0) |=> (wb_result_o == $past(rd_mask_i & mem_rdata)));
endmodule

bind scalar_dmem_stage scalar_dmem_stage_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_kind_i    (req_kind_i),
  .rd_mask_i     (rd_mask_i),
  .wr_mask_i     (wr_mask_i),
  .shamt_i       (shamt_i),
  .pass_result_i (pass_result_i),
  .pass_dest_i   (pass_dest_i),
  .wb_result_o   (wb_result_o),
  .wb_dest_o     (wb_dest_o),
  .mem_we        (mem_we),
  .mem_rdata     (mem_rdata),
  .mem_wdata     (mem_wdata)
);

// File: tb/scalar_dmem_stage_tb.sv
module scalar_dmem_stage_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  req_kind_i = 2'b00;
  logic [31:0] addr_i = '0, rd_mask_i = '0, wr_mask_i = '0, st_data_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] pass_result_i = '0;
  logic [4:0]  pass_dest_i = '0;
  logic [31:0] wb_result_o;
  logic [4:0]  wb_dest_o;

  int n_vec = 0, n_bad = 0;
  logic [31:0] model [1024];

  always #2 clk_i = ~clk_i;

  scalar_dmem_stage u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_kind_i(req_kind_i), .addr_i(addr_i),
    .rd_mask_i(rd_mask_i), .wr_mask_i(wr_mask_i), .st_data_i(st_data_i),
    .shamt_i(shamt_i), .pass_result_i(pass_result_i), .pass_dest_i(pass_dest_i),
    .wb_result_o(wb_result_o), .wb_dest_o(wb_dest_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request at a falling edge; returns after the capturing edge, at the next falling edge.
  task automatic issue(logic [1:0] k, logic [31:0] a, logic [31:0] rm, logic [31:0] wm,
                       logic [31:0] d, logic [4:0] sh, logic [31:0] pr, logic [4:0] pd,
                       output logic [31:0] exp_res, output logic [4:0] exp_dst);
    logic [31:0] w;
    w = model[a[11:2]];
    exp_res = pr;
    exp_dst = pd;
    if (k == 2'b01) begin
      exp_res = rm & 32'($signed(w) >>> sh);
      model[a[11:2]] = (w & ~wm) | (d & wm);
    end else if (k[1]) begin
      exp_dst = 5'd0;
    end
    req_kind_i = k; addr_i = a; rd_mask_i = rm; wr_mask_i = wm;
    st_data_i = d; shamt_i = sh; pass_result_i = pr; pass_dest_i = pd;
    @(posedge clk_i);
    @(negedge clk_i);
    req_kind_i = 2'b00;
  endtask

  task automatic store_word(logic [11:0] a, logic [31:0] d);
    logic [31:0] r; logic [4:0] t;
    issue(2'b01, {20'h0, a}, 32'h0, 32'hFFFF_FFFF, d, 5'd0, 32'h0, 5'd0, r, t);
  endtask

  task automatic peek(string req, logic [31:0] a, logic [31:0] exp_word);
    logic [31:0] r; logic [4:0] t;
    issue(2'b01, a, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd0, 32'h0, 5'd1, r, t);
    check(req, wb_result_o, exp_word);
    check(req, r, exp_word);
  endtask

  task automatic t_reset;
    check("R1 result", wb_result_o, 32'h0);
    check("R1 dest", {27'h0, wb_dest_o}, 32'h0);
  endtask

  task automatic t_loads;
    logic [31:0] r; logic [4:0] t;
    store_word(12'h010, 32'h80F1_7F22);
    // signed byte at offset 0 (bits 31:24)
    issue(2'b01, 32'h010, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd24, 32'h0, 5'd3, r, t);
    check("R3 signed byte0", wb_result_o, 32'hFFFF_FF80);
    check("R8 dest", {27'h0, wb_dest_o}, 32'd3);
    // unsigned byte at offset 1
    issue(2'b01, 32'h011, 32'h0000_00FF, 32'h0, 32'h0, 5'd16, 32'h0, 5'd4, r, t);
    check("R3 unsigned byte1", wb_result_o, 32'h0000_00F1);
    // signed half at offset 2 (positive)
    issue(2'b01, 32'h012, 32'hFFFF_FFFF, 32'h0, 32'h0, 5'd0, 32'h0, 5'd4, r, t);
    check("R3 full word", wb_result_o, r);
    issue(2'b01, 32'h012, 32'h0000_FFFF, 32'h0, 32'h0, 5'd0, 32'h0, 5'd4, r, t);
    check("R3 half low", wb_result_o, 32'h0000_7F22);
  endtask

  task automatic t_stores;
    store_word(12'h020, 32'h1122_3344);
    begin
      logic [31:0] r; logic [4:0] t;
      issue(2'b01, 32'h021, 32'h0, 32'h00FF_0000, 32'h00AB_0000, 5'd0, 32'h0, 5'd0, r, t);
    end
    peek("R4 byte1 merge", 32'h020, 32'h11AB_3344);
    peek("R4 model", 32'h020, model[12'h020 >> 2]);
  endtask

  task automatic t_zero_mask_alias;
    logic [31:0] r; logic [4:0] t;
    store_word(12'h100, 32'hCAFE_BABE);
    issue(2'b01, 32'hABCD_E100, 32'h0, 32'h0, 32'hFFFF_FFFF, 5'd0, 32'h0, 5'd0, r, t);
    peek("R5 zero mask", 32'h100, 32'hCAFE_BABE);
    peek("R2 alias read", 32'h5555_5103, 32'hCAFE_BABE);
  endtask

  task automatic t_idle_vector;
    logic [31:0] r; logic [4:0] t;
    store_word(12'h200, 32'h0BAD_F00D);
    issue(2'b00, 32'h200, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h1234_5678, 5'd9, r, t);
    check("R6 idle result", wb_result_o, 32'h1234_5678);
    check("R6 idle dest", {27'h0, wb_dest_o}, 32'd9);
    issue(2'b10, 32'h200, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h9ABC_DEF0, 5'd17, r, t);
    check("R7 vec result", wb_result_o, 32'h9ABC_DEF0);
    check("R7 vec dest", {27'h0, wb_dest_o}, 32'd0);
    issue(2'b11, 32'h200, 32'h0, 32'hFFFF_FFFF, 32'h0, 5'd0, 32'h0000_0001, 5'd31, r, t);
    check("R7 vec alt dest", {27'h0, wb_dest_o}, 32'd0);
    peek("R6 R7 memory kept", 32'h200, 32'h0BAD_F00D);
  endtask

  task automatic t_rmw_b2b;
    logic [31:0] r; logic [4:0] t;
    store_word(12'h300, 32'hDEAD_BEEF);
    issue(2'b01, 32'h300, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_1234, 5'd0, 32'h0, 5'd2, r, t);
    check("R9 old value", wb_result_o, 32'hDEAD_BEEF);
    peek("R10 next cycle sees write", 32'h300, 32'hDEAD_1234);
    store_word(12'h304, 32'h0000_0001);
    peek("R10 back to back", 32'h304, 32'h0000_0001);
  endtask

  initial begin
    fork
      begin
        #6 t_reset();
        @(negedge clk_i); rst_ni = 1'b1;
        @(negedge clk_i);
        t_loads();
        t_stores();
        t_zero_mask_alias();
        t_idle_vector();
        t_rmw_b2b();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule